// File: doc/BRIEF.md
# Masked Window Register Copier

This block is a small copy engine that moves data out of a local memory into a configuration register space in windows of eight 32-bit words (32 bytes). For each window an eight-bit word mask selects which words are actually written to the destination. Words that are masked out are still read from the source and still advance both addresses, so the layout of the window is kept.

Software sets up the job through a simple register port. It writes a word mask, a source base, a destination base and a control word. The control word holds a window count and an interrupt enable. Writing the control word starts the job. If a job is already running, the new job is held as pending. It starts as soon as the running job ends, without an idle cycle between the two. Two status bits show whether a job is running and whether one is waiting. The engine is idle only when both bits are zero. The engine reads the source through a one-word read port whose data returns one cycle after the request. It writes the destination through a separate one-word write port. When interrupts are enabled, it pulses an interrupt line at the end of the job.

Top module: `masked_window_copier`

## Requirements
- R1: After reset every register reads zero, the status is zero, and irq, mem_req and cfg_we are low.
- R2: A count field value of N copies N+1 consecutive windows, and a value of zero copies exactly one window of eight words.
- R3: For each word, the engine raises mem_req with the source address. In the next cycle it writes the returned data to the matching destination address. Inside a window, the words go in ascending order in 4-byte steps, and each window starts 32 bytes after the one before it.
- R4: Mask bit i set to 1 suppresses the destination write of word i in every window of the job. A suppressed word still advances both addresses.
- R5: Bit 16 of the control word is the interrupt enable. When it is set, irq is high for exactly one cycle, in the cycle after the job's final word cycle. When it is clear, irq stays low.
- R6: Register word index 0 is the mask (bits 7:0). Index 1 is the source base and index 2 is the destination base. Index 3 is the control word: count in bits 7:0, interrupt enable in bit 16. Index 4 is the read-only status: bit 0 active, bit 1 pending. Reads return the values that were programmed.
- R7: The low five bits of the source and destination bases are ignored and read back as zero, so every job starts on a 32-byte boundary.
- R8: After a control write to an idle engine, the status reads pending=1, active=0 for exactly one cycle. It then reads active=1, pending=0.
- R9: A control write while a job is active sets pending and leaves the running job alone. Pending clears at the running job's last word cycle, and the queued job issues its first read in the next cycle while active stays 1.
- R10: The engine issues no reads and no writes while the status reads zero. It stays idle until the control word is written.
- R11: Each job uses the mask and addresses that were present when its control word was written. Writes to those registers during a job do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Source read request |
| mem_addr | output | 32 | Source byte address |
| mem_rdata | input | 32 | Source data, valid the cycle after mem_req |
| cfg_we | output | 1 | Destination write strobe |
| cfg_addr | output | 32 | Destination byte address |
| cfg_wdata | output | 32 | Destination write data |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions assume that the source memory returns data exactly one cycle after each mem_req and never stalls. They also assume that reg_we is a single-cycle strobe that is never held across a control write. The bench's memory model answers every request on the next edge with a value derived from the address. It drives each register write for one cycle, away from the clock edge. Queued-job stimulus writes the control word only while the status shows a job running, so the overlap path is exercised without depending on contention at the exact edge a job finishes.

// File: rtl/cpy_pkg.sv
package cpy_pkg;

    parameter int AW       = 32;   // address width
    parameter int DW       = 32;   // data width
    parameter int WORDS    = 8;    // words per window (power of two)
    parameter int CW       = 8;    // count field width
    parameter int IRQ_BIT  = 16;   // interrupt-enable bit in the control word
    parameter int RAW      = 3;    // register index width

    localparam int IDXW      = $clog2(WORDS);
    localparam int STEP      = DW / 8;
    localparam int WIN_BYTES = WORDS * STEP;
    localparam int ALIGN     = $clog2(WIN_BYTES);

    localparam logic [RAW-1:0] IX_MASK = 3'd0;
    localparam logic [RAW-1:0] IX_SRC  = 3'd1;
    localparam logic [RAW-1:0] IX_DST  = 3'd2;
    localparam logic [RAW-1:0] IX_CTRL = 3'd3;
    localparam logic [RAW-1:0] IX_STAT = 3'd4;

    typedef struct packed {
        logic [WORDS-1:0] mask;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [CW-1:0]    windows;
        logic             irq_en;
    } job_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_state_t;

    function automatic logic [AW-1:0] win_align(input logic [AW-1:0] a);
        return {a[AW-1:ALIGN], {ALIGN{1'b0}}};
    endfunction

endpackage

// File: rtl/cpy_regs.sv
module cpy_regs
    import cpy_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           busy,
    input  logic           take,
    output logic           pend_valid,
    output job_t           pend_job
);

    logic [WORDS-1:0] mask_q;
    logic [AW-1:0]    src_q;
    logic [AW-1:0]    dst_q;
    logic [CW-1:0]    cnt_q;
    logic             irqen_q;
    logic             pend_q;
    job_t             job_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            irqen_q <= 1'b0;
            pend_q  <= 1'b0;
            job_q   <= '0;
        end else begin
            if (take) begin
                pend_q <= 1'b0;
            end
            if (reg_we) begin
                case (reg_addr)
                    IX_MASK: mask_q <= reg_wdata[WORDS-1:0];
                    IX_SRC:  src_q  <= win_align(reg_wdata[AW-1:0]);
                    IX_DST:  dst_q  <= win_align(reg_wdata[AW-1:0]);
                    IX_CTRL: begin
                        cnt_q          <= reg_wdata[CW-1:0];
                        irqen_q        <= reg_wdata[IRQ_BIT];
                        job_q.mask     <= mask_q;
                        job_q.src      <= src_q;
                        job_q.dst      <= dst_q;
                        job_q.windows  <= reg_wdata[CW-1:0];
                        job_q.irq_en   <= reg_wdata[IRQ_BIT];
                        pend_q         <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IX_MASK: reg_rdata[WORDS-1:0] = mask_q;
            IX_SRC:  reg_rdata = src_q;
            IX_DST:  reg_rdata = dst_q;
            IX_CTRL: begin
                reg_rdata[CW-1:0]    = cnt_q;
                reg_rdata[IRQ_BIT]   = irqen_q;
            end
            IX_STAT: begin
                reg_rdata[0] = busy;
                reg_rdata[1] = pend_q;
            end
            default: ;
        endcase
    end

    assign pend_valid = pend_q;
    assign pend_job   = job_q;

    // R9: a waiting job is handed over as soon as the engine can take it
    assert_pending_taken_R9: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !busy && !(reg_we && reg_addr == IX_CTRL)) |=> !pend_q);

endmodule

// File: rtl/cpy_engine.sv
module cpy_engine
    import cpy_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          pend_valid,
    input  job_t          pend_job,
    output logic          take,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          cfg_we,
    output logic [AW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_wdata,
    output logic          irq
);

    eng_state_t       st_q;
    logic [IDXW-1:0]  idx_q;
    logic [CW-1:0]    left_q;
    logic [AW-1:0]    sp_q;
    logic [AW-1:0]    dp_q;
    logic [WORDS-1:0] mask_q;
    logic             irqen_q;
    logic             irq_q;
    logic             last_word;
    logic             finish;

    assign last_word = (idx_q == IDXW'(WORDS - 1));
    assign finish    = (st_q == ST_WRITE) && last_word && (left_q == '0);
    assign take      = pend_valid && ((st_q == ST_IDLE) || finish);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            left_q  <= '0;
            sp_q    <= '0;
            dp_q    <= '0;
            mask_q  <= '0;
            irqen_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= finish && irqen_q;
            if (take) begin
                st_q    <= ST_READ;
                idx_q   <= '0;
                left_q  <= pend_job.windows;
                sp_q    <= pend_job.src;
                dp_q    <= pend_job.dst;
                mask_q  <= pend_job.mask;
                irqen_q <= pend_job.irq_en;
            end else begin
                case (st_q)
                    ST_READ: st_q <= ST_WRITE;
                    ST_WRITE: begin
                        sp_q <= sp_q + AW'(STEP);
                        dp_q <= dp_q + AW'(STEP);
                        if (last_word) begin
                            idx_q <= '0;
                            if (left_q == '0) begin
                                st_q <= ST_IDLE;
                            end else begin
                                left_q <= left_q - 1'b1;
                                st_q   <= ST_READ;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ST_READ;
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        busy      = (st_q != ST_IDLE);
        mem_req   = (st_q == ST_READ);
        mem_addr  = sp_q;
        cfg_we    = (st_q == ST_WRITE) && !mask_q[idx_q];
        cfg_addr  = dp_q;
        cfg_wdata = mem_rdata;
        irq       = irq_q;
    end

    // R3: every destination write carries data requested one cycle earlier
    assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> $past(mem_req));

    // R5: completion interrupt lasts one cycle
    assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R5: interrupt only directly after a running job
    assert_irq_after_job_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(busy));

endmodule

// File: rtl/masked_window_copier.sv
module masked_window_copier
    import cpy_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           cfg_we,
    output logic [AW-1:0]  cfg_addr,
    output logic [DW-1:0]  cfg_wdata,
    output logic           irq
);

    logic busy;
    logic take;
    logic pend_valid;
    job_t pend_job;

    cpy_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_job   (pend_job)
    );

    cpy_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .pend_valid (pend_valid),
        .pend_job   (pend_job),
        .take       (take),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .irq        (irq)
    );

    // R8: a job only becomes active out of the pending slot
    assert_start_from_pending_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(pend_valid));

    // R10: with nothing waiting and no register write, the engine stays idle
    assert_stay_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pend_valid && !reg_we) |=> !busy);

endmodule

// File: tb/test_masked_window_copier.sv
`timescale 1ns/1ps
module test_masked_window_copier;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        cfg_we;
    logic [31:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic        irq;

    masked_window_copier i_masked_window_copier (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq(irq)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    int          cap_n = 0;
    logic [31:0] cap_addr [64];
    logic [31:0] cap_data [64];
    int          cap_cyc  [64];
    int          irq_cnt = 0;
    int          irq_cyc = 0;
    int          exp_n = 0;
    logic [31:0] exp_addr [64];
    logic [31:0] exp_data [64];

    function automatic logic [31:0] src_val(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    // source memory: one-cycle latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) mem_rdata <= src_val(mem_addr);
    end

    always @(negedge clk) begin
        if (cfg_we && cap_n < 64) begin
            cap_addr[cap_n] = cfg_addr;
            cap_data[cap_n] = cfg_wdata;
            cap_cyc[cap_n]  = cyc;
            cap_n++;
        end
        if (irq) begin
            irq_cnt++;
            irq_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] ix, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ix; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] ix, output logic [31:0] v);
        reg_addr = ix;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            rd(3'd4, s);
            if (s == 0) return;
        end
        chk(1'b0, "R10 idle timeout", s, 0);
    endtask

    task automatic clear_log();
        cap_n = 0; exp_n = 0; irq_cnt = 0;
    endtask

    task automatic expect_job(input logic [7:0] m, input logic [31:0] s, input logic [31:0] d, input int cnt);
        logic [31:0] sa = {s[31:5], 5'b0};
        logic [31:0] da = {d[31:5], 5'b0};
        for (int w = 0; w <= cnt; w++)
            for (int i = 0; i < 8; i++)
                if (!m[i] && exp_n < 64) begin
                    exp_addr[exp_n] = da + 32'(32*w + 4*i);
                    exp_data[exp_n] = src_val(sa + 32'(32*w + 4*i));
                    exp_n++;
                end
    endtask

    task automatic compare(input string req);
        chk(cap_n == exp_n, {req, " write count"}, cap_n, exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            chk(cap_addr[k] == exp_addr[k], {req, " address"}, cap_addr[k], exp_addr[k]);
            chk(cap_data[k] == exp_data[k], {req, " data"}, cap_data[k], exp_data[k]);
        end
    endtask

    task automatic start(input logic [7:0] m, input logic [31:0] s, input logic [31:0] d,
                         input int cnt, input bit ie);
        wr(3'd0, {24'd0, m});
        wr(3'd1, s);
        wr(3'd2, d);
        wr(3'd3, {15'd0, ie, 8'd0, 8'(cnt)});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int ix = 0; ix < 5; ix++) begin
            rd(3'(ix), v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        chk(!irq && !mem_req && !cfg_we, "R1 outputs reset", {irq, mem_req, cfg_we}, 0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        clear_log();
        start(8'h00, 32'h0000_0100, 32'h0200_4000, 0, 1'b1);
        rd(3'd3, v);
        chk(v == 32'h0001_0000, "R6 control readback", v, 32'h0001_0000);
        wait_idle();
        expect_job(8'h00, 32'h100, 32'h0200_4000, 0);
        compare("R2 R3 single window");
        chk(irq_cnt == 1, "R5 irq count", irq_cnt, 1);
        chk(irq_cyc == cap_cyc[cap_n-1] + 1, "R5 irq timing", irq_cyc, cap_cyc[cap_n-1] + 1);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        clear_log();
        start(8'h5A, 32'h0000_0400, 32'h0300_0000, 2, 1'b0);
        rd(3'd0, v);
        chk(v == 32'h5A, "R6 mask readback", v, 32'h5A);
        wait_idle();
        expect_job(8'h5A, 32'h400, 32'h0300_0000, 2);
        compare("R4 masked three windows");
        chk(irq_cnt == 0, "R5 irq disabled", irq_cnt, 0);
    endtask

    task automatic t_full_mask();
        clear_log();
        start(8'hFF, 32'h0000_0800, 32'h0300_1000, 1, 1'b1);
        wait_idle();
        chk(cap_n == 0, "R4 all words masked", cap_n, 0);
        chk(irq_cnt == 1, "R5 irq with full mask", irq_cnt, 1);
    endtask

    task automatic t_align();
        logic [31:0] v;
        clear_log();
        start(8'h81, 32'h0000_1A3F, 32'h0400_201D, 0, 1'b0);
        rd(3'd1, v);
        chk(v == 32'h0000_1A20, "R7 source aligned", v, 32'h0000_1A20);
        rd(3'd2, v);
        chk(v == 32'h0400_2000, "R7 destination aligned", v, 32'h0400_2000);
        wait_idle();
        expect_job(8'h81, 32'h1A3F, 32'h0400_201D, 0);
        compare("R7 aligned copy");
    endtask

    task automatic t_handshake();
        logic [31:0] s;
        clear_log();
        wr(3'd0, 32'h0); wr(3'd1, 32'h40); wr(3'd2, 32'h80);
        chk(!mem_req && !cfg_we, "R10 quiet before start", {mem_req, cfg_we}, 0);
        wr(3'd3, 32'h0);
        rd(3'd4, s);
        chk(s == 32'h2, "R8 pending first", s, 32'h2);
        @(negedge clk);
        rd(3'd4, s);
        chk(s == 32'h1, "R8 then active", s, 32'h1);
        wait_idle();
        chk(cap_n == 8, "R8 job ran", cap_n, 8);
    endtask

    task automatic t_queue();
        logic [31:0] s;
        int a_last;
        clear_log();
        start(8'h00, 32'h0000_0100, 32'h0500_0000, 0, 1'b1);
        // reprogram while job A runs, then queue job B
        wr(3'd0, 32'hF0);
        wr(3'd1, 32'h0000_0800);
        wr(3'd2, 32'h0600_0000);
        rd(3'd4, s);
        chk(s == 32'h1, "R11 A still active alone", s, 32'h1);
        wr(3'd3, 32'h0000_0001);
        rd(3'd4, s);
        chk(s == 32'h3, "R9 active and pending", s, 32'h3);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            rd(3'd4, s);
            if (s != 32'h3) break;
        end
        chk(s == 32'h1, "R9 pending cleared while active", s, 32'h1);
        wait_idle();
        expect_job(8'h00, 32'h100, 32'h0500_0000, 0);
        expect_job(8'hF0, 32'h800, 32'h0600_0000, 1);
        compare("R9 R11 queued jobs");
        a_last = (cap_n > 8) ? cap_cyc[7] : 0;
        if (cap_n > 8)
            chk(cap_cyc[8] == a_last + 2, "R9 no idle gap", cap_cyc[8], a_last + 2);
        chk(irq_cnt == 1, "R5 irq only for A", irq_cnt, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_masked();
        t_full_mask();
        t_align();
        t_handshake();
        t_queue();
        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule